// File: doc/BRIEF.md
# Programmable Watchdog Timer

The block is a free-running supervision timer. It counts pulses of an external time-base tick, one pulse per 100 ms step for example. When the host fails to restart it in time, it raises a fault. A 5-bit interval code in a control byte sets how many ticks make up one interval. A restart happens only when a fixed 4-bit key is written to the command register. Writing the control byte alone changes nothing in the running interval. The new code is loaded only by the next valid restart.

Each fault restarts the interval and sets a sticky fault flag. If the enable bit is set, the fault also drives an active-low reset output low for a fixed number of system clocks. If the enable bit is clear, the timer keeps counting and only the flag records the fault. For this reason the host should restart the timer before it sets the enable bit.

Top module: `wdog_timer`

## Requirements
- R1: After reset, `rst_out_n` is 1, `fault_flag` is 0, the enable bit is 0, and both the pending and the active interval code are 0.
- R2: With an active code N from 1 to 30, the fault occurs on the N-th tick after a restart. The flag is visible in the clock cycle after that tick.
- R3: Active code 0 is treated as an interval of one tick.
- R4: Active code 31 (all ones) stops the count, and no fault occurs while it is active.
- R5: A command write (`wr_sel`=1) restarts the interval only when `wr_data[3:0]` is 4'b1010. Any other value in that field has no effect on the count. A restart and a tick in the same cycle leave the count at zero.
- R6: A control write changes only the pending code. The pending code becomes the active code at the next valid restart.
- R7: When the enable bit is 1, a fault drives `rst_out_n` low for exactly RST_CYCLES (default 16) clock cycles, starting in the cycle after the fault. A fault during a running pulse starts the pulse again.
- R8: When the enable bit is 0, a fault leaves `rst_out_n` at 1 and only sets the flag.
- R9: `fault_flag` stays set until a command write with `wr_data[7]`=1 clears it. If a fault and a clear happen in the same cycle, the flag is set.
- R10: A fault restarts the interval, so the next fault comes after another full interval.
- R11: In the control byte (`wr_sel`=0), bit 7 is the enable bit and bits 4:0 are the interval code. Bits 6:5 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base pulse, one clock wide per interval step |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control byte, 1 selects the command register |
| wr_data | input | 8 | Write data |
| rst_out_n | output | 1 | Active-low reset request |
| fault_flag | output | 1 | Sticky fault indication |

## Verification
Tick trains of different lengths are run against codes 0, 1, 2, 3, 5 and 31. These runs separate the one-tick fallback, the normal N-tick interval and the stopped counter. Restart attempts with the key and with wrong nibbles show whether only the exact key restarts the interval. Control writes made without a later restart show whether the new code is applied too early. Faults with the enable bit at 1 and at 0, and a fault that coincides with a flag clear, separate the reset-pulse path from the flag path and set their priority.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int WD_DATA_W  = 8;
    localparam int WD_CODE_W  = 5;
    localparam int WD_KEY_W   = 4;
    localparam logic [WD_KEY_W-1:0] WD_KICK_KEY = 4'b1010;
    localparam int WD_EN_BIT  = 7;
    localparam int WD_CLR_BIT = 7;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int DATA_W  = WD_DATA_W,
    parameter int CODE_W  = WD_CODE_W,
    parameter int KEY_W   = WD_KEY_W,
    parameter logic [KEY_W-1:0] KEY = WD_KICK_KEY,
    parameter int EN_BIT  = WD_EN_BIT,
    parameter int CLR_BIT = WD_CLR_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              enable,
    output logic [CODE_W-1:0] code_pend,
    output logic              kick,
    output logic              clr
);
    typedef struct packed {
        logic              en;
        logic [CODE_W-1:0] code;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  unused_data;

    assign unused_data = ^wr_data;

    always_comb begin
        ctrl_d = ctrl_q;
        kick   = 1'b0;
        clr    = 1'b0;
        if (wr_en && !wr_sel) begin
            ctrl_d.en   = wr_data[EN_BIT];
            ctrl_d.code = wr_data[CODE_W-1:0];
        end
        if (wr_en && wr_sel) begin
            kick = (wr_data[KEY_W-1:0] == KEY);
            clr  = wr_data[CLR_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign enable    = ctrl_q.en;
    assign code_pend = ctrl_q.code;

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && !wr_sel) |=> ($stable(enable) && $stable(code_pend))); // R11
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int CODE_W = WD_CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              kick,
    input  logic [CODE_W-1:0] code_pend,
    output logic              fault
);
    localparam logic [CODE_W-1:0] STOP_CODE = '1;
    localparam logic [CODE_W:0]   ONE       = (CODE_W+1)'(1);

    typedef struct packed {
        logic [CODE_W-1:0] count;
        logic [CODE_W-1:0] active;
    } cnt_t;

    cnt_t              s_d, s_q;
    logic [CODE_W:0]   limit;
    logic [CODE_W:0]   next_cnt;
    logic              stopped;

    always_comb begin
        s_d      = s_q;
        fault    = 1'b0;
        stopped  = (s_q.active == STOP_CODE);
        limit    = (s_q.active == '0) ? ONE : {1'b0, s_q.active};
        next_cnt = {1'b0, s_q.count} + ONE;
        if (kick) begin
            s_d.count  = '0;
            s_d.active = code_pend;
        end else if (tick && !stopped) begin
            if (next_cnt >= limit) begin
                fault     = 1'b1;
                s_d.count = '0;
            end else begin
                s_d.count = next_cnt[CODE_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active != STOP_CODE) |-> ({1'b0, s_q.count} < limit)); // R2
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stopped && !kick) |=> $stable(s_q.count)); // R4
    AST_KICK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (s_q.count == '0)); // R5
    AST_CODE_ON_KICK: assert property (@(posedge clk) disable iff (!rst_n)
        !kick |=> $stable(s_q.active)); // R6
    AST_FAULT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> (s_q.count == '0)); // R10
endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault,
    input  logic enable,
    input  logic clr,
    output logic rst_out_n,
    output logic flag
);
    localparam int PW = $clog2(RST_CYCLES + 1);
    localparam logic [PW-1:0] PULSE_LEN = PW'(RST_CYCLES);

    typedef struct packed {
        logic [PW-1:0] pulse;
        logic          flag;
    } rg_t;

    rg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (fault && enable)       r_d.pulse = PULSE_LEN;
        else if (r_q.pulse != '0)  r_d.pulse = r_q.pulse - 1'b1;
        if (fault)                 r_d.flag = 1'b1;
        else if (clr)              r_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rst_out_n = (r_q.pulse == '0);
    assign flag      = r_q.flag;

    AST_FAULT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> flag); // R9
    AST_FAULT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && enable) |=> !rst_out_n); // R7
    AST_NO_RST_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !enable && rst_out_n) |=> rst_out_n); // R8
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 wr_en,
    input  logic                 wr_sel,
    input  logic [WD_DATA_W-1:0] wr_data,
    output logic                 rst_out_n,
    output logic                 fault_flag
);
    logic                 enable;
    logic [WD_CODE_W-1:0] code_pend;
    logic                 kick;
    logic                 clr;
    logic                 fault;

    wdog_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .enable    (enable),
        .code_pend (code_pend),
        .kick      (kick),
        .clr       (clr)
    );

    wdog_counter u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .kick      (kick),
        .code_pend (code_pend),
        .fault     (fault)
    );

    wdog_rstgen #(.RST_CYCLES(RST_CYCLES)) u_rstgen (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault     (fault),
        .enable    (enable),
        .clr       (clr),
        .rst_out_n (rst_out_n),
        .flag      (fault_flag)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |-> (rst_out_n && !fault_flag)); // R1
endmodule

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;
    localparam int RSTC = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rst_out_n;
    logic       fault_flag;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // behavioural reference state
    int m_count = 0, m_active = 0, m_pend = 0, m_en = 0, m_flag = 0, m_pulse = 0;

    always #2.5 clk = ~clk;

    wdog_timer #(.RST_CYCLES(RSTC)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rst_out_n(rst_out_n), .fault_flag(fault_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_count = 0; m_active = 0; m_pend = 0; m_en = 0; m_flag = 0; m_pulse = 0;
        end else begin
            bit kick, clr, flt;
            int lim;
            kick = wr_en && wr_sel && (wr_data[3:0] == 4'b1010);
            clr  = wr_en && wr_sel && wr_data[7];
            lim  = (m_active == 0) ? 1 : m_active;
            flt  = tick && !kick && (m_active != 31) && (m_count + 1 >= lim);
            if (kick) begin
                m_count = 0; m_active = m_pend;
            end else if (tick && m_active != 31) begin
                m_count = flt ? 0 : m_count + 1;
            end
            if (flt && m_en != 0) m_pulse = RSTC;
            else if (m_pulse > 0) m_pulse--;
            if (flt) m_flag = 1;
            else if (clr) m_flag = 0;
            if (wr_en && !wr_sel) begin
                m_en = wr_data[7]; m_pend = wr_data[4:0];
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R7 per-cycle rst_out_n vs model", rst_out_n, (m_pulse == 0) ? 1 : 0);
            chk("R9 per-cycle fault_flag vs model", fault_flag, m_flag);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=<50000 cycles", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(input bit t, input bit we, input bit sel, input logic [7:0] d);
        tick = t; wr_en = we; wr_sel = sel; wr_data = d;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = 8'h00;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic ctrl(input logic [7:0] d); step(1'b0, 1'b1, 1'b0, d); endtask
    task automatic cmd(input logic [7:0] d);  step(1'b0, 1'b1, 1'b1, d); endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset rst_out_n", rst_out_n, 1);
        chk("R1 reset fault_flag", fault_flag, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: code 0 after reset gives one-tick interval
        ticks(1);
        chk("R3 code 0 faults on first tick", fault_flag, 1);
        cmd(8'h80);
        chk("R9 flag cleared by bit 7", fault_flag, 0);

        // R6: pending code not active before restart
        ctrl(8'h03);
        ticks(1);
        chk("R6 old code 0 still active", fault_flag, 1);
        cmd(8'h80);
        cmd(8'h0A);
        ticks(2);
        chk("R2 code 3 no fault after 2 ticks", fault_flag, 0);
        ticks(1);
        chk("R2 code 3 fault on 3rd tick", fault_flag, 1);
        chk("R8 disabled fault keeps rst high", rst_out_n, 1);

        // R10: fault restarts interval
        cmd(8'h80);
        ticks(2);
        chk("R10 no fault 2 ticks after fault", fault_flag, 0);
        ticks(1);
        chk("R10 fault after full interval", fault_flag, 1);

        // R5: wrong key ignored
        cmd(8'h80);
        cmd(8'h0A);
        ticks(2);
        cmd(8'h0B);
        cmd(8'h05);
        ticks(1);
        chk("R5 wrong nibble did not restart", fault_flag, 1);
        cmd(8'h80);
        ticks(2);
        step(1'b1, 1'b1, 1'b1, 8'h0A);
        chk("R5 restart with tick same cycle", fault_flag, 0);
        ticks(2);
        chk("R5 count from zero after restart", fault_flag, 0);
        ticks(1);
        chk("R5 fault 3 ticks after restart", fault_flag, 1);

        // R11: bits 6:5 ignored, code 5 enable 0
        cmd(8'h80);
        ctrl(8'h65);
        cmd(8'h0A);
        ticks(4);
        chk("R11 code 5 no fault after 4", fault_flag, 0);
        ticks(1);
        chk("R11 code 5 fault on 5th tick", fault_flag, 1);
        chk("R11 enable bit 0 no reset", rst_out_n, 1);

        // R7: enabled reset pulse length
        ctrl(8'h82);
        cmd(8'h8A);
        chk("R9 clear with restart", fault_flag, 0);
        ticks(2);
        chk("R7 reset low after fault", rst_out_n, 0);
        repeat (RSTC - 1) step(1'b0, 1'b0, 1'b0, 8'h00);
        chk("R7 reset still low at last cycle", rst_out_n, 0);
        step(1'b0, 1'b0, 1'b0, 8'h00);
        chk("R7 reset released after RST_CYCLES", rst_out_n, 1);

        // R9: set wins over clear
        ctrl(8'h01);
        cmd(8'h0A);
        step(1'b1, 1'b1, 1'b1, 8'h80);
        chk("R9 fault beats clear", fault_flag, 1);

        // R4: stop code
        ctrl(8'h1F);
        cmd(8'h8A);
        ticks(40);
        chk("R4 stopped counter no fault", fault_flag, 0);
        ctrl(8'h01);
        ticks(5);
        chk("R6 pending code waits for restart", fault_flag, 0);
        cmd(8'h0A);
        ticks(1);
        chk("R6 new code 1 after restart", fault_flag, 1);
        chk("R8 enable 0 keeps rst high", rst_out_n, 1);

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule